// File: doc/BRIEF.md
# Software (XON/XOFF) Flow Controller

This block handles in-band software flow control for one serial channel. On the receive side, every incoming character is compared against four programmable control characters: two "resume" codes (ON1, ON2) and two "stop" codes (OFF1, OFF2). A recognised stop code raises a halt flag that keeps the local transmitter from starting a new data character. A recognised resume code clears the flag. Recognised control characters are taken out of the stream. All other characters are passed on to the receive FIFO write port. The character being shifted out when the flag rises is allowed to finish, because the flag only gates the start of the next data character.

On the transmit side, the block watches the receive FIFO fill level. When the level reaches the programmed halt threshold, it asks the transmitter to insert a stop code. When the level later drains to the resume threshold, it asks for a resume code. Both thresholds are coded in units of eight FIFO words. A pending insertion always wins over ordinary FIFO data at the transmitter.

Two independent 2-bit mode fields choose which control characters are matched and which are generated. A master enable switches the whole function on and off.

Top module: `swf_ctrl`

## Requirements
- R1: After reset, `tx_halt`, `ins_valid` and `fifo_wr_valid` are 0 and `tx_data_ok` is 1.
- R2: While `cfg_enable` is 0 or `rx_mode` is 00, every received character is forwarded to the FIFO write port, including control codes. In this state `tx_halt` is 0 from the clock edge after the condition is sampled.
- R3: With `rx_mode` = 01, ON2 clears the halt flag and OFF2 sets it. ON1 and OFF1 are forwarded as data.
- R4: With `rx_mode` = 10, ON1 clears the halt flag and OFF1 sets it. ON2 and OFF2 are forwarded as data.
- R5: With `rx_mode` = 11, the halt flag is set only by the pair OFF1 then OFF2, and cleared only by the pair ON1 then ON2. The first character of a pair is held back. If the next character does not complete the pair, the held character and then the new one reach the FIFO in arrival order. Received characters must be at least two clock cycles apart.
- R6: A matched control character never produces a FIFO write. Its effect on `tx_halt` is visible one clock edge after `rx_valid` is sampled. Data received while halted is still forwarded, and the flag is unchanged.
- R7: `tx_data_ok` is 1 exactly when `tx_halt` is 0 and no insertion is pending (`ins_valid` is 0).
- R8: A stop request is raised once when `rx_fill` is at least 8 × `lvl_halt`. A resume request is raised once, after a stop, when `rx_fill` is at most 8 × `lvl_resume`. Only one request is outstanding at a time.
- R9: The generated codes depend on `tx_mode`:
  - 01 gives OFF2 or ON2.
  - 10 gives OFF1 or ON1.
  - 11 gives OFF1 followed by OFF2, or ON1 followed by ON2.
- R10: A request holds `ins_valid` high and `ins_char` steady until `ins_ready` is sampled high. Each accepted handshake transfers one character.
- R11: With `tx_mode` = 00 or `cfg_enable` = 0, no insertion request is raised, whatever the fill level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Master enable for software flow control |
| rx_mode | input | 2 | Receive matching mode (00 off, 01 set 2, 10 set 1, 11 pairs) |
| tx_mode | input | 2 | Transmit generation mode (00 off, 01 set 2, 10 set 1, 11 pairs) |
| chr_on1 | input | 8 | Resume character 1 |
| chr_on2 | input | 8 | Resume character 2 |
| chr_off1 | input | 8 | Stop character 1 |
| chr_off2 | input | 8 | Stop character 2 |
| lvl_halt | input | 4 | Halt threshold in units of 8 words |
| lvl_resume | input | 4 | Resume threshold in units of 8 words |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | 8 | Received character |
| fifo_wr_valid | output | 1 | Write strobe to the receive FIFO |
| fifo_wr_data | output | 8 | Character written to the receive FIFO |
| tx_halt | output | 1 | Local transmitter halted by the remote side |
| rx_fill | input | 8 | Receive FIFO fill level in words |
| ins_valid | output | 1 | Control-character insertion request |
| ins_char | output | 8 | Character to insert |
| ins_ready | input | 1 | Transmitter accepts the inserted character |
| tx_data_ok | output | 1 | Transmitter may start a FIFO data character |

## Verification
The receive path is tested with the same stop and resume codes under each matching mode. A code that is consumed in one mode must be forwarded in another, so this shows whether mode decoding, not just comparison, is right.

In pair mode, both complete and broken sequences are used. A broken sequence shows whether the held character is released, and in the correct order. Ordinary data sent while halted shows that the flag is unaffected by data.

The transmit path is driven with fill levels just below and exactly at each threshold. This exposes any off-by-one in the ×8 scaling and shows that requests are not repeated. A stalled handshake checks that the request is held steady. Each generation mode is also checked for the exact character order it produces.

// File: rtl/swf_pkg.sv
package swf_pkg;

  // Mode encoding shared by receive matching and transmit generation.
  typedef enum logic [1:0] {
    FC_NONE = 2'b00,
    FC_SET2 = 2'b01,
    FC_SET1 = 2'b10,
    FC_BOTH = 2'b11
  } fc_mode_e;

  // Insertion sequencer state.
  typedef enum logic [1:0] {
    GEN_IDLE   = 2'b00,
    GEN_FIRST  = 2'b01,
    GEN_SECOND = 2'b10
  } gen_st_e;

  // Positions of the control characters in the comparison table.
  localparam int IDX_ON1  = 0;
  localparam int IDX_ON2  = 1;
  localparam int IDX_OFF1 = 2;
  localparam int IDX_OFF2 = 3;
  localparam int NUM_CHR  = 4;

endpackage

// File: rtl/swf_chr_cmp.sv
module swf_chr_cmp #(
  parameter int CW = 8,
  parameter int N  = 4
) (
  input  logic [N*CW-1:0] ref_tbl,
  input  logic [CW-1:0]   chr,
  output logic [N-1:0]    hit
);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit[g] = (chr == ref_tbl[g*CW +: CW]);
  end

endmodule

// File: rtl/swf_rx_match.sv
module swf_rx_match
  import swf_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [1:0]    mode,
  input  logic [NUM_CHR-1:0] hit,
  input  logic          rx_valid,
  input  logic [CW-1:0] rx_char,
  output logic          wr_valid,
  output logic [CW-1:0] wr_data,
  output logic          halt
);

  logic          active;
  logic          on_hit, off_hit;
  logic          held_vld_q, held_vld_n;
  logic [CW-1:0] held_chr_q, held_chr_n;
  logic          held_off_q, held_off_n;
  logic          defer_vld_q, defer_vld_n;
  logic [CW-1:0] defer_chr_q, defer_chr_n;
  logic          wr_vld_q, wr_vld_n;
  logic [CW-1:0] wr_chr_q, wr_chr_n;
  logic          halt_q, halt_n;
  logic          slot_busy, take;

  assign active = en && (mode != FC_NONE);

  always_comb begin
    on_hit  = 1'b0;
    off_hit = 1'b0;
    if (mode == FC_SET2) begin
      on_hit  = hit[IDX_ON2];
      off_hit = hit[IDX_OFF2];
    end else if (mode == FC_SET1) begin
      on_hit  = hit[IDX_ON1];
      off_hit = hit[IDX_OFF1];
    end
  end

  always_comb begin
    held_vld_n  = held_vld_q;
    held_chr_n  = held_chr_q;
    held_off_n  = held_off_q;
    defer_vld_n = 1'b0;
    defer_chr_n = defer_chr_q;
    wr_vld_n    = 1'b0;
    wr_chr_n    = wr_chr_q;
    halt_n      = halt_q;
    slot_busy   = 1'b0;
    take        = 1'b0;

    if (defer_vld_q) begin
      wr_vld_n  = 1'b1;
      wr_chr_n  = defer_chr_q;
      slot_busy = 1'b1;
    end

    // Leaving pair mode releases a held first character.
    if (held_vld_q && !(active && mode == FC_BOTH)) begin
      wr_vld_n   = 1'b1;
      wr_chr_n   = held_chr_q;
      held_vld_n = 1'b0;
      slot_busy  = 1'b1;
    end

    if (!active) begin
      halt_n = 1'b0;
    end

    if (rx_valid) begin
      if (!active) begin
        take = 1'b1;
      end else if (mode != FC_BOTH) begin
        if (on_hit) begin
          halt_n = 1'b0;
        end else if (off_hit) begin
          halt_n = 1'b1;
        end else begin
          take = 1'b1;
        end
      end else begin
        if (held_vld_q && !held_off_q && hit[IDX_ON2]) begin
          halt_n     = 1'b0;
          held_vld_n = 1'b0;
        end else if (held_vld_q && held_off_q && hit[IDX_OFF2]) begin
          halt_n     = 1'b1;
          held_vld_n = 1'b0;
        end else begin
          if (held_vld_q) begin
            wr_vld_n   = 1'b1;
            wr_chr_n   = held_chr_q;
            held_vld_n = 1'b0;
            slot_busy  = 1'b1;
          end
          if (hit[IDX_ON1] || hit[IDX_OFF1]) begin
            held_vld_n = 1'b1;
            held_chr_n = rx_char;
            held_off_n = !hit[IDX_ON1];
          end else begin
            take = 1'b1;
          end
        end
      end

      if (take) begin
        if (slot_busy) begin
          defer_vld_n = 1'b1;
          defer_chr_n = rx_char;
        end else begin
          wr_vld_n = 1'b1;
          wr_chr_n = rx_char;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_vld_q  <= 1'b0;
      held_chr_q  <= '0;
      held_off_q  <= 1'b0;
      defer_vld_q <= 1'b0;
      defer_chr_q <= '0;
      wr_vld_q    <= 1'b0;
      wr_chr_q    <= '0;
      halt_q      <= 1'b0;
    end else begin
      held_vld_q  <= held_vld_n;
      defer_vld_q <= defer_vld_n;
      wr_vld_q    <= wr_vld_n;
      halt_q      <= halt_n;
      if (held_vld_n)  held_chr_q  <= held_chr_n;
      if (held_vld_n)  held_off_q  <= held_off_n;
      if (defer_vld_n) defer_chr_q <= defer_chr_n;
      if (wr_vld_n)    wr_chr_q    <= wr_chr_n;
    end
  end

  assign wr_valid = wr_vld_q;
  assign wr_data  = wr_chr_q;
  assign halt     = halt_q;

endmodule

// File: rtl/swf_tx_gen.sv
module swf_tx_gen
  import swf_pkg::*;
#(
  parameter int CW         = 8,
  parameter int LVL_W      = 4,
  parameter int FILL_W     = 8,
  parameter int UNIT_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [1:0]        mode,
  input  logic [CW-1:0]     on1,
  input  logic [CW-1:0]     on2,
  input  logic [CW-1:0]     off1,
  input  logic [CW-1:0]     off2,
  input  logic [LVL_W-1:0]  lvl_halt,
  input  logic [LVL_W-1:0]  lvl_resume,
  input  logic [FILL_W-1:0] fill,
  input  logic              ins_ready,
  output logic              ins_valid,
  output logic [CW-1:0]     ins_char
);

  localparam int SCALED_W = LVL_W + UNIT_SHIFT;
  localparam int CMP_W    = ((FILL_W > SCALED_W) ? FILL_W : SCALED_W) + 1;

  gen_st_e          st_q, st_n;
  logic             send_off_q, send_off_n;
  logic             stopped_q, stopped_n;
  logic             active;
  logic [CMP_W-1:0] fill_x, halt_words, resume_words;

  assign active       = en && (mode != FC_NONE);
  assign fill_x       = CMP_W'(fill);
  assign halt_words   = CMP_W'(lvl_halt) << UNIT_SHIFT;
  assign resume_words = CMP_W'(lvl_resume) << UNIT_SHIFT;

  always_comb begin
    st_n       = st_q;
    send_off_n = send_off_q;
    stopped_n  = stopped_q;
    if (!active) begin
      st_n      = GEN_IDLE;
      stopped_n = 1'b0;
    end else begin
      case (st_q)
        GEN_IDLE: begin
          if (!stopped_q && (fill_x >= halt_words)) begin
            st_n       = GEN_FIRST;
            send_off_n = 1'b1;
            stopped_n  = 1'b1;
          end else if (stopped_q && (fill_x <= resume_words)) begin
            st_n       = GEN_FIRST;
            send_off_n = 1'b0;
            stopped_n  = 1'b0;
          end
        end
        GEN_FIRST: begin
          if (ins_ready) st_n = (mode == FC_BOTH) ? GEN_SECOND : GEN_IDLE;
        end
        GEN_SECOND: begin
          if (ins_ready) st_n = GEN_IDLE;
        end
        default: st_n = GEN_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= GEN_IDLE;
      send_off_q <= 1'b0;
      stopped_q  <= 1'b0;
    end else begin
      st_q       <= st_n;
      send_off_q <= send_off_n;
      stopped_q  <= stopped_n;
    end
  end

  always_comb begin
    ins_char = '0;
    if (st_q == GEN_SECOND || (st_q == GEN_FIRST && mode == FC_SET2)) begin
      ins_char = send_off_q ? off2 : on2;
    end else if (st_q == GEN_FIRST) begin
      ins_char = send_off_q ? off1 : on1;
    end
  end

  assign ins_valid = (st_q != GEN_IDLE);

endmodule

// File: rtl/swf_ctrl.sv
module swf_ctrl
  import swf_pkg::*;
#(
  parameter int CHAR_W     = 8,
  parameter int LVL_W      = 4,
  parameter int FILL_W     = 8,
  parameter int UNIT_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic [1:0]        rx_mode,
  input  logic [1:0]        tx_mode,
  input  logic [CHAR_W-1:0] chr_on1,
  input  logic [CHAR_W-1:0] chr_on2,
  input  logic [CHAR_W-1:0] chr_off1,
  input  logic [CHAR_W-1:0] chr_off2,
  input  logic [LVL_W-1:0]  lvl_halt,
  input  logic [LVL_W-1:0]  lvl_resume,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_char,
  output logic              fifo_wr_valid,
  output logic [CHAR_W-1:0] fifo_wr_data,
  output logic              tx_halt,
  input  logic [FILL_W-1:0] rx_fill,
  output logic              ins_valid,
  output logic [CHAR_W-1:0] ins_char,
  input  logic              ins_ready,
  output logic              tx_data_ok
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0]    rst_pipe;
  logic                      rst_s_n;
  logic [NUM_CHR*CHAR_W-1:0] chr_tbl;
  logic [NUM_CHR-1:0]        chr_hit;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_s_n = rst_pipe[SYNC_STAGES-1];

  assign chr_tbl = {chr_off2, chr_off1, chr_on2, chr_on1};

  swf_chr_cmp #(.CW(CHAR_W), .N(NUM_CHR)) u_cmp (
    .ref_tbl (chr_tbl),
    .chr     (rx_char),
    .hit     (chr_hit)
  );

  swf_rx_match #(.CW(CHAR_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .en       (cfg_enable),
    .mode     (rx_mode),
    .hit      (chr_hit),
    .rx_valid (rx_valid),
    .rx_char  (rx_char),
    .wr_valid (fifo_wr_valid),
    .wr_data  (fifo_wr_data),
    .halt     (tx_halt)
  );

  swf_tx_gen #(
    .CW(CHAR_W), .LVL_W(LVL_W), .FILL_W(FILL_W), .UNIT_SHIFT(UNIT_SHIFT)
  ) u_tx (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .en         (cfg_enable),
    .mode       (tx_mode),
    .on1        (chr_on1),
    .on2        (chr_on2),
    .off1       (chr_off1),
    .off2       (chr_off2),
    .lvl_halt   (lvl_halt),
    .lvl_resume (lvl_resume),
    .fill       (rx_fill),
    .ins_ready  (ins_ready),
    .ins_valid  (ins_valid),
    .ins_char   (ins_char)
  );

  assign tx_data_ok = !tx_halt && !ins_valid;

endmodule

// File: rtl/swf_ctrl_chk.sv
module swf_ctrl_chk #(
  parameter int CHAR_W     = 8,
  parameter int LVL_W      = 4,
  parameter int FILL_W     = 8,
  parameter int UNIT_SHIFT = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_enable,
  input logic [1:0]        rx_mode,
  input logic [1:0]        tx_mode,
  input logic [CHAR_W-1:0] chr_on1,
  input logic [CHAR_W-1:0] chr_on2,
  input logic [CHAR_W-1:0] chr_off1,
  input logic [CHAR_W-1:0] chr_off2,
  input logic [LVL_W-1:0]  lvl_halt,
  input logic [LVL_W-1:0]  lvl_resume,
  input logic              rx_valid,
  input logic [CHAR_W-1:0] rx_char,
  input logic              fifo_wr_valid,
  input logic [CHAR_W-1:0] fifo_wr_data,
  input logic              tx_halt,
  input logic [FILL_W-1:0] rx_fill,
  input logic              ins_valid,
  input logic [CHAR_W-1:0] ins_char,
  input logic              ins_ready,
  input logic              tx_data_ok
);

  // R2
  disabled_no_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> !tx_halt);

  // R4
  set1_off_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && rx_mode == 2'b10 && rx_valid && rx_char == chr_off1 && rx_char != chr_on1)
    |=> tx_halt);

  // R6
  set2_on_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && rx_mode == 2'b01 && rx_valid && rx_char == chr_on2 &&
     $past(cfg_enable) && $past(rx_mode) == 2'b01)
    |=> !fifo_wr_valid);

  // R10
  request_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ins_valid) |-> ($past(ins_ready) || !$past(cfg_enable) || $past(tx_mode) == 2'b00));

  // R11
  gen_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mode == 2'b00) |=> !ins_valid);

endmodule

bind swf_ctrl swf_ctrl_chk #(
  .CHAR_W(CHAR_W), .LVL_W(LVL_W), .FILL_W(FILL_W), .UNIT_SHIFT(UNIT_SHIFT)
) u_chk (.*);

// File: tb/swf_ctrl_tb.sv
module swf_ctrl_tb;

  localparam logic [7:0] ON1  = 8'h11;
  localparam logic [7:0] OFF1 = 8'h13;
  localparam logic [7:0] ON2  = 8'h91;
  localparam logic [7:0] OFF2 = 8'h93;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_enable;
  logic [1:0] rx_mode, tx_mode;
  logic [3:0] lvl_halt, lvl_resume;
  logic       rx_valid;
  logic [7:0] rx_char;
  logic       fifo_wr_valid;
  logic [7:0] fifo_wr_data;
  logic       tx_halt;
  logic [7:0] rx_fill;
  logic       ins_valid;
  logic [7:0] ins_char;
  logic       ins_ready;
  logic       tx_data_ok;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] wr_q[$];
  logic [7:0] ins_q[$];

  always #4 clk = ~clk;

  swf_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
    .rx_mode(rx_mode), .tx_mode(tx_mode),
    .chr_on1(ON1), .chr_on2(ON2), .chr_off1(OFF1), .chr_off2(OFF2),
    .lvl_halt(lvl_halt), .lvl_resume(lvl_resume),
    .rx_valid(rx_valid), .rx_char(rx_char),
    .fifo_wr_valid(fifo_wr_valid), .fifo_wr_data(fifo_wr_data),
    .tx_halt(tx_halt), .rx_fill(rx_fill),
    .ins_valid(ins_valid), .ins_char(ins_char), .ins_ready(ins_ready),
    .tx_data_ok(tx_data_ok)
  );

  always @(negedge clk) begin
    if (fifo_wr_valid) wr_q.push_back(fifo_wr_data);
    if (ins_valid && ins_ready) ins_q.push_back(ins_char);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] c);
    rx_valid = 1'b1;
    rx_char  = c;
    tick(1);
    rx_valid = 1'b0;
    tick(1);
  endtask

  task automatic expect_writes(input string req, input logic [7:0] e0, input logic [7:0] e1, input int n);
    chk(wr_q.size() == n, req, wr_q.size(), n);
    if (n > 0 && wr_q.size() > 0) chk(wr_q[0] == e0, req, wr_q[0], e0);
    if (n > 1 && wr_q.size() > 1) chk(wr_q[1] == e1, req, wr_q[1], e1);
    wr_q.delete();
  endtask

  task automatic expect_ins(input string req, input logic [7:0] e0, input logic [7:0] e1, input int n);
    chk(ins_q.size() == n, req, ins_q.size(), n);
    if (n > 0 && ins_q.size() > 0) chk(ins_q[0] == e0, req, ins_q[0], e0);
    if (n > 1 && ins_q.size() > 1) chk(ins_q[1] == e1, req, ins_q[1], e1);
    ins_q.delete();
  endtask

  task automatic t_reset();
    chk(tx_halt == 1'b0, "R1 halt", tx_halt, 0);
    chk(ins_valid == 1'b0, "R1 ins_valid", ins_valid, 0);
    chk(fifo_wr_valid == 1'b0, "R1 wr_valid", fifo_wr_valid, 0);
    chk(tx_data_ok == 1'b1, "R1 data_ok", tx_data_ok, 1);
  endtask

  task automatic t_disabled();
    cfg_enable = 1'b0; rx_mode = 2'b10;
    tick(1); wr_q.delete();
    send(OFF1);
    chk(tx_halt == 1'b0, "R2 halt", tx_halt, 0);
    expect_writes("R2 forward", OFF1, 8'h00, 1);
    cfg_enable = 1'b1; rx_mode = 2'b00;
    send(OFF2);
    expect_writes("R2 mode00 forward", OFF2, 8'h00, 1);
  endtask

  task automatic t_set2();
    cfg_enable = 1'b1; rx_mode = 2'b01;
    tick(1); wr_q.delete();
    send(OFF1);
    expect_writes("R3 off1 forwarded", OFF1, 8'h00, 1);
    send(OFF2);
    chk(tx_halt == 1'b1, "R3 off2 halts", tx_halt, 1);
    chk(tx_data_ok == 1'b0, "R7 halted blocks data", tx_data_ok, 0);
    expect_writes("R6 off2 consumed", 8'h00, 8'h00, 0);
    send(8'h41);
    chk(tx_halt == 1'b1, "R6 data keeps halt", tx_halt, 1);
    expect_writes("R6 data while halted", 8'h41, 8'h00, 1);
    send(ON2);
    chk(tx_halt == 1'b0, "R3 on2 resumes", tx_halt, 0);
    chk(tx_data_ok == 1'b1, "R7 resumed", tx_data_ok, 1);
    expect_writes("R6 on2 consumed", 8'h00, 8'h00, 0);
  endtask

  task automatic t_set1();
    rx_mode = 2'b10;
    tick(1); wr_q.delete();
    send(OFF2);
    chk(tx_halt == 1'b0, "R4 off2 ignored", tx_halt, 0);
    expect_writes("R4 off2 forwarded", OFF2, 8'h00, 1);
    send(OFF1);
    chk(tx_halt == 1'b1, "R4 off1 halts", tx_halt, 1);
    send(ON1);
    chk(tx_halt == 1'b0, "R4 on1 resumes", tx_halt, 0);
    expect_writes("R4 consumed", 8'h00, 8'h00, 0);
  endtask

  task automatic t_pairs();
    rx_mode = 2'b11;
    tick(1); wr_q.delete();
    send(OFF1);
    chk(tx_halt == 1'b0, "R5 half pair", tx_halt, 0);
    send(OFF2);
    chk(tx_halt == 1'b1, "R5 off pair halts", tx_halt, 1);
    send(ON1);
    send(ON2);
    chk(tx_halt == 1'b0, "R5 on pair resumes", tx_halt, 0);
    expect_writes("R5 pairs consumed", 8'h00, 8'h00, 0);
    send(OFF1);
    send(8'h55);
    tick(1);
    chk(tx_halt == 1'b0, "R5 broken no halt", tx_halt, 0);
    expect_writes("R5 broken order", OFF1, 8'h55, 2);
    send(ON1);
    send(OFF1);
    send(OFF2);
    chk(tx_halt == 1'b1, "R5 restart pair", tx_halt, 1);
    expect_writes("R5 on1 released", ON1, 8'h00, 1);
    send(ON1);
    send(ON2);
    chk(tx_halt == 1'b0, "R5 clear again", tx_halt, 0);
    rx_mode = 2'b00;
    tick(2);
    wr_q.delete();
  endtask

  task automatic t_gen_set1();
    tx_mode = 2'b10; lvl_halt = 4'd8; lvl_resume = 4'd4;
    rx_fill = 8'd63; ins_ready = 1'b1;
    tick(4);
    expect_ins("R8 below halt", 8'h00, 8'h00, 0);
    ins_ready = 1'b0;
    rx_fill = 8'd64;
    tick(3);
    chk(ins_valid == 1'b1, "R10 request pending", ins_valid, 1);
    chk(ins_char == OFF1, "R9 set1 off", ins_char, OFF1);
    chk(tx_data_ok == 1'b0, "R10 priority", tx_data_ok, 0);
    tick(2);
    chk(ins_valid == 1'b1 && ins_char == OFF1, "R10 held", ins_char, OFF1);
    ins_ready = 1'b1;
    tick(6);
    expect_ins("R8 single off", OFF1, 8'h00, 1);
    chk(tx_data_ok == 1'b1, "R7 free again", tx_data_ok, 1);
    rx_fill = 8'd33;
    tick(4);
    expect_ins("R8 above resume", 8'h00, 8'h00, 0);
    rx_fill = 8'd32;
    tick(6);
    expect_ins("R8 single on", ON1, 8'h00, 1);
  endtask

  task automatic t_gen_set2();
    tx_mode = 2'b01;
    rx_fill = 8'd64;
    tick(5);
    expect_ins("R9 set2 off", OFF2, 8'h00, 1);
    rx_fill = 8'd0;
    tick(5);
    expect_ins("R9 set2 on", ON2, 8'h00, 1);
  endtask

  task automatic t_gen_both();
    tx_mode = 2'b11;
    rx_fill = 8'd80;
    tick(6);
    expect_ins("R9 both off", OFF1, OFF2, 2);
    rx_fill = 8'd10;
    tick(6);
    expect_ins("R9 both on", ON1, ON2, 2);
  endtask

  task automatic t_gen_off();
    tx_mode = 2'b00;
    rx_fill = 8'd127;
    tick(6);
    chk(ins_valid == 1'b0, "R11 mode00 idle", ins_valid, 0);
    expect_ins("R11 no codes", 8'h00, 8'h00, 0);
    tx_mode = 2'b10; cfg_enable = 1'b0;
    tick(6);
    expect_ins("R11 disabled", 8'h00, 8'h00, 0);
    cfg_enable = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; cfg_enable = 1'b0; rx_mode = 2'b00; tx_mode = 2'b00;
    lvl_halt = 4'd8; lvl_resume = 4'd4; rx_valid = 1'b0; rx_char = 8'h00;
    rx_fill = 8'd0; ins_ready = 1'b1;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_disabled();
    t_set2();
    t_set1();
    t_pairs();
    t_gen_set1();
    t_gen_set2();
    t_gen_both();
    t_gen_off();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule